// File: doc/BRIEF.md
# Tagged Circular Register Stack

This block holds eight data registers used as a circular stack for a floating-point datapath. A 3-bit top field chooses which physical entry is the current top (ST0). Every operand is named relative to the top, so STi lives in physical entry (top + i) mod 8. Each entry has a tag bit that says whether it holds a value. Moving the pointer and changing tags are separate actions. The pointer can therefore rotate without changing any tag, and entries can be marked empty without erasing their data.

A client issues at most one command per clock. It raises `cmd_valid` and gives a 4-bit opcode, a 3-bit register index and two data words. All state changes on the next rising edge. ST0 and a freely chosen STi can be read at any time, combinationally, whatever their tags say. A push onto an occupied entry is refused and raises the overflow flag. A command that needs an empty operand to hold a value is refused and raises the underflow flag. Each flag is high for the one cycle after the offending command.

Top module: `fp_reg_stack`

## Requirements
- R1: After reset the top field is 0, all tags are empty, all eight data entries read 0 and both flags are low.
- R2: Opcode 1 (push) with the entry at (top-1) mod 8 empty moves top to (top-1) mod 8, stores `push_data` there and sets its tag.
- R3: A push (opcode 1) whose target entry at (top-1) mod 8 is full raises `overflow_o` for the next cycle and leaves top, tags and data unchanged.
- R4: Opcode 2 (pop) clears the tag of ST0 and advances top by one. If ST0 is empty, it raises `underflow_o` instead and changes nothing.
- R5: Opcode 3 (double pop) clears the tags of ST0 and ST1 and advances top by two. If either entry is empty, it raises `underflow_o` and changes nothing.
- R6: Opcode 4 (write then push) stores `res_data` into ST0 and then pushes `push_data`. Afterwards `res_data` is ST1 and `push_data` is ST0, and both are tagged full. It follows the overflow rule of R3.
- R7: Opcode 5 adds one to top and opcode 6 subtracts one from top (mod 8). Neither changes any tag or data value.
- R8: Opcode 7 marks ST(`cmd_idx`) empty. Opcode 8 does the same and then clears the tag of ST0 and advances top by one, without raising underflow.
- R9: Opcode 9 swaps the data of ST0 and ST(`cmd_idx`); index 0 selects ST1. Tags do not change. If either entry is empty, it raises `underflow_o` and nothing changes.
- R10: Opcode 10 clears all tags and sets top to 0 without changing any stored data value.
- R11: With `cmd_valid` low, or for opcode 0 or opcodes 11 to 15, no state changes and both flags are low on the next cycle.
- R12: `st0_q` shows the entry at physical index top, and `sti_q` the entry at (top + `rd_idx`) mod 8, whatever their tags. `tag_full` bit k is 1 when physical entry k is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Opcode |
| cmd_idx | input | 3 | Relative register index for free and exchange |
| push_data | input | DATA_W | Value pushed by opcodes 1 and 4 |
| res_data | input | DATA_W | Value written to ST0 by opcode 4 |
| rd_idx | input | 3 | Relative index of the second read port |
| st0_q | output | DATA_W | Contents of ST0 |
| sti_q | output | DATA_W | Contents of ST(rd_idx) |
| top_q | output | 3 | Top field |
| tag_full | output | 8 | Per physical entry full tag |
| overflow_o | output | 1 | Refused push in the previous cycle |
| underflow_o | output | 1 | Empty operand in the previous cycle |

## Verification
The bench aims at the wrap of the top field through 7 and 0. A design with wrong modular arithmetic would write or free the wrong physical entry there. It fills all eight entries and pushes again: a design that does not guard pushes would overwrite the oldest value and lose it silently. It checks that initialise and the two rotations keep data and tags. A design that cleared storage on initialise, or emptied an entry during a rotation, would read back zeros or show a changed tag vector. It runs exchange with index 0 and double pops with only one entry full. Here a design would swap ST0 with itself, or pop the full entry before it saw the empty one.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_PUSH   = 4'd1,
    OP_POP    = 4'd2,
    OP_POP2   = 4'd3,
    OP_WRPUSH = 4'd4,
    OP_INCP   = 4'd5,
    OP_DECP   = 4'd6,
    OP_FREE   = 4'd7,
    OP_FREEP  = 4'd8,
    OP_XCHG   = 4'd9,
    OP_INIT   = 4'd10
  } stk_op_e;
endpackage

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
  import fpstk_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(NREG)
) (
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [PTR_W-1:0]  cmd_idx,
  input  logic [PTR_W-1:0]  top_q,
  input  logic [NREG-1:0]   tag_q,
  input  logic [DATA_W-1:0] push_data,
  input  logic [DATA_W-1:0] res_data,
  input  logic [DATA_W-1:0] st0_val,
  input  logic [DATA_W-1:0] mate_val,
  output logic [PTR_W-1:0]  mate_addr,
  output logic [PTR_W-1:0]  top_nxt,
  output logic [NREG-1:0]   tag_nxt,
  output logic              wa_en,
  output logic [PTR_W-1:0]  wa_addr,
  output logic [DATA_W-1:0] wa_data,
  output logic              wb_en,
  output logic [PTR_W-1:0]  wb_addr,
  output logic [DATA_W-1:0] wb_data,
  output logic              ovf_nxt,
  output logic              unf_nxt
);
  logic [PTR_W-1:0] p_up1, p_up2, p_dn1, p_rel;
  stk_op_e          op;

  assign op    = stk_op_e'(cmd_op);
  assign p_up1 = top_q + PTR_W'(1);
  assign p_up2 = top_q + PTR_W'(2);
  assign p_dn1 = top_q - PTR_W'(1);
  assign p_rel = top_q + cmd_idx;
  // exchange with index 0 pairs ST0 with ST1
  assign mate_addr = (op == OP_XCHG && cmd_idx == '0) ? p_up1 : p_rel;

  always_comb begin
    top_nxt = top_q;
    tag_nxt = tag_q;
    wa_en   = 1'b0;
    wa_addr = top_q;
    wa_data = push_data;
    wb_en   = 1'b0;
    wb_addr = top_q;
    wb_data = push_data;
    ovf_nxt = 1'b0;
    unf_nxt = 1'b0;
    if (cmd_valid) begin
      case (op)
        OP_PUSH: begin
          if (tag_q[p_dn1]) begin
            ovf_nxt = 1'b1;
          end else begin
            top_nxt        = p_dn1;
            tag_nxt[p_dn1] = 1'b1;
            wa_en          = 1'b1;
            wa_addr        = p_dn1;
            wa_data        = push_data;
          end
        end
        OP_POP: begin
          if (!tag_q[top_q]) begin
            unf_nxt = 1'b1;
          end else begin
            tag_nxt[top_q] = 1'b0;
            top_nxt        = p_up1;
          end
        end
        OP_POP2: begin
          if (!tag_q[top_q] || !tag_q[p_up1]) begin
            unf_nxt = 1'b1;
          end else begin
            tag_nxt[top_q] = 1'b0;
            tag_nxt[p_up1] = 1'b0;
            top_nxt        = p_up2;
          end
        end
        OP_WRPUSH: begin
          if (tag_q[p_dn1]) begin
            ovf_nxt = 1'b1;
          end else begin
            wa_en          = 1'b1;
            wa_addr        = top_q;
            wa_data        = res_data;
            tag_nxt[top_q] = 1'b1;
            wb_en          = 1'b1;
            wb_addr        = p_dn1;
            wb_data        = push_data;
            tag_nxt[p_dn1] = 1'b1;
            top_nxt        = p_dn1;
          end
        end
        OP_INCP: top_nxt = p_up1;
        OP_DECP: top_nxt = p_dn1;
        OP_FREE: tag_nxt[p_rel] = 1'b0;
        OP_FREEP: begin
          tag_nxt[p_rel] = 1'b0;
          tag_nxt[top_q] = 1'b0;
          top_nxt        = p_up1;
        end
        OP_XCHG: begin
          if (!tag_q[top_q] || !tag_q[mate_addr]) begin
            unf_nxt = 1'b1;
          end else begin
            wa_en   = 1'b1;
            wa_addr = top_q;
            wa_data = mate_val;
            wb_en   = 1'b1;
            wb_addr = mate_addr;
            wb_data = st0_val;
          end
        end
        OP_INIT: begin
          tag_nxt = '0;
          top_nxt = '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fpstk_regfile.sv
module fpstk_regfile #(
  parameter int NREG   = 8,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wa_en,
  input  logic [PTR_W-1:0]  wa_addr,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wb_en,
  input  logic [PTR_W-1:0]  wb_addr,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [PTR_W-1:0]  ra0,
  input  logic [PTR_W-1:0]  ra1,
  input  logic [PTR_W-1:0]  ra2,
  output logic [DATA_W-1:0] rd0,
  output logic [DATA_W-1:0] rd1,
  output logic [DATA_W-1:0] rd2
);
  logic [DATA_W-1:0] mem_q [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_entry
    logic              hit_a, hit_b, en;
    logic [DATA_W-1:0] d_nxt;
    assign hit_a = wa_en && (wa_addr == PTR_W'(k));
    assign hit_b = wb_en && (wb_addr == PTR_W'(k));
    assign en    = hit_a || hit_b;
    always_comb begin
      d_nxt = mem_q[k];
      if (hit_a) d_nxt = wa_data;
      if (hit_b) d_nxt = wb_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q[k] <= '0;
      else if (en) mem_q[k] <= d_nxt;
    end
  end

  assign rd0 = mem_q[ra0];
  assign rd1 = mem_q[ra1];
  assign rd2 = mem_q[ra2];

  // the two write ports never aim at one entry in the same cycle (R6, R9)
  p_port_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wa_en && wb_en && wa_addr == wb_addr));
endmodule

// File: rtl/fp_reg_stack.sv
module fp_reg_stack
  import fpstk_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [PTR_W-1:0]  cmd_idx,
  input  logic [DATA_W-1:0] push_data,
  input  logic [DATA_W-1:0] res_data,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] st0_q,
  output logic [DATA_W-1:0] sti_q,
  output logic [PTR_W-1:0]  top_q,
  output logic [NREG-1:0]   tag_full,
  output logic              overflow_o,
  output logic              underflow_o
);
  logic [PTR_W-1:0]  top_nxt, mate_addr, wa_addr, wb_addr;
  logic [NREG-1:0]   tag_nxt;
  logic              wa_en, wb_en, ovf_nxt, unf_nxt;
  logic [DATA_W-1:0] wa_data, wb_data, mate_val;

  fpstk_ctrl #(.NREG(NREG), .DATA_W(DATA_W)) u_ctrl (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
    .top_q(top_q), .tag_q(tag_full), .push_data(push_data), .res_data(res_data),
    .st0_val(st0_q), .mate_val(mate_val), .mate_addr(mate_addr),
    .top_nxt(top_nxt), .tag_nxt(tag_nxt),
    .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .ovf_nxt(ovf_nxt), .unf_nxt(unf_nxt)
  );

  fpstk_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .ra0(top_q), .ra1(top_q + rd_idx), .ra2(mate_addr),
    .rd0(st0_q), .rd1(sti_q), .rd2(mate_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q    <= '0;
      tag_full <= '0;
    end else if (cmd_valid) begin
      top_q    <= top_nxt;
      tag_full <= tag_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      overflow_o  <= ovf_nxt;
      underflow_o <= unf_nxt;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PUSH && tag_full[top_q - PTR_W'(1)])
      |=> (overflow_o && $stable(top_q) && $stable(tag_full)));

  p_push_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PUSH && !tag_full[top_q - PTR_W'(1)])
      |=> (top_q == PTR_W'($past(top_q) - PTR_W'(1)) && tag_full[top_q] && !overflow_o));

  p_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_POP && !tag_full[top_q])
      |=> (underflow_o && $stable(top_q)));

  p_rotate_tags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == OP_INCP || cmd_op == OP_DECP)) |=> $stable(tag_full));

  p_init_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_INIT) |=> (top_q == '0 && tag_full == '0));

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(top_q) && $stable(tag_full) && !overflow_o && !underflow_o));

  p_flag_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(overflow_o && underflow_o));
endmodule

// File: tb/fp_reg_stack_test.sv
`timescale 1ns/1ps
module fp_reg_stack_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [3:0]  cmd_op;
  logic [2:0]  cmd_idx, rd_idx;
  logic [31:0] push_data, res_data, st0_q, sti_q;
  logic [2:0]  top_q;
  logic [7:0]  tag_full;
  logic        overflow_o, underflow_o;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_data [8];
  logic [7:0]  m_tag;
  logic [2:0]  m_top;
  logic        e_ovf, e_unf;

  always #2.5 clk = ~clk;

  fp_reg_stack uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .push_data(push_data), .res_data(res_data),
    .rd_idx(rd_idx), .st0_q(st0_q), .sti_q(sti_q), .top_q(top_q),
    .tag_full(tag_full), .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    logic [2:0] a;
    a = m_top + rd_idx;
    check(req, "top", {29'd0, top_q}, {29'd0, m_top});
    check(req, "tags", {24'd0, tag_full}, {24'd0, m_tag});
    check(req, "st0", st0_q, m_data[m_top]);
    check("R12", "sti", sti_q, m_data[a]);
    check(req, "ovf", {31'd0, overflow_o}, {31'd0, e_ovf});
    check(req, "unf", {31'd0, underflow_o}, {31'd0, e_unf});
  endtask

  // reference model of one accepted command
  task automatic model(input int op, input logic [2:0] idx,
                       input logic [31:0] pd, input logic [31:0] rd,
                       output string req);
    logic [2:0] p1, p2, pm, px, pt;
    logic [31:0] t;
    p1 = m_top + 3'd1; p2 = m_top + 3'd2; pm = m_top - 3'd1; px = m_top + idx;
    e_ovf = 1'b0; e_unf = 1'b0;
    case (op)
      1: begin req = "R2";
        if (m_tag[pm]) begin e_ovf = 1'b1; req = "R3"; end
        else begin m_top = pm; m_data[pm] = pd; m_tag[pm] = 1'b1; end
      end
      2: begin req = "R4";
        if (!m_tag[m_top]) e_unf = 1'b1;
        else begin m_tag[m_top] = 1'b0; m_top = p1; end
      end
      3: begin req = "R5";
        if (!m_tag[m_top] || !m_tag[p1]) e_unf = 1'b1;
        else begin m_tag[m_top] = 1'b0; m_tag[p1] = 1'b0; m_top = p2; end
      end
      4: begin req = "R6";
        if (m_tag[pm]) e_ovf = 1'b1;
        else begin
          m_data[m_top] = rd; m_tag[m_top] = 1'b1;
          m_data[pm] = pd; m_tag[pm] = 1'b1; m_top = pm;
        end
      end
      5: begin req = "R7"; m_top = p1; end
      6: begin req = "R7"; m_top = pm; end
      7: begin req = "R8"; m_tag[px] = 1'b0; end
      8: begin req = "R8"; m_tag[px] = 1'b0; m_tag[m_top] = 1'b0; m_top = p1; end
      9: begin req = "R9";
        pt = (idx == 3'd0) ? p1 : px;
        if (!m_tag[m_top] || !m_tag[pt]) e_unf = 1'b1;
        else begin t = m_data[m_top]; m_data[m_top] = m_data[pt]; m_data[pt] = t; end
      end
      10: begin req = "R10"; m_tag = '0; m_top = '0; end
      default: req = "R11";
    endcase
  endtask

  task automatic do_cmd(input int op, input logic [2:0] idx,
                        input logic [31:0] pd, input logic [31:0] rd);
    string req;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 4'(op); cmd_idx = idx;
    push_data = pd; res_data = rd; rd_idx = 3'($urandom % 8);
    model(op, idx, pd, rd, req);
    @(negedge clk);
    cmd_valid = 1'b0;
    compare_all(req);
  endtask

  task automatic do_idle(input int op);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 4'(op); cmd_idx = 3'd2;
    push_data = $urandom; res_data = $urandom;
    e_ovf = 1'b0; e_unf = 1'b0;
    @(negedge clk);
    compare_all("R11");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_idx = '0;
    push_data = '0; res_data = '0; rd_idx = '0;
    for (int k = 0; k < 8; k++) m_data[k] = '0;
    m_tag = '0; m_top = '0; e_ovf = 1'b0; e_unf = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state, all entries zero
    for (int k = 0; k < 8; k++) begin
      @(negedge clk) rd_idx = 3'(k);
      #0.5 check("R1", "entry", sti_q, 32'd0);
    end
    compare_all("R1");

    // R4: pop on empty
    do_cmd(2, 3'd0, 32'd0, 32'd0);
    // fill all eight, wrapping top through 7..0, then overflow (R3)
    for (int k = 0; k < 8; k++) do_cmd(1, 3'd0, 32'hA000_0000 + 32'(k), 32'd0);
    do_cmd(1, 3'd0, 32'hDEAD_BEEF, 32'd0);
    do_cmd(4, 3'd0, 32'h1111_1111, 32'h2222_2222);
    // R9: exchange with default partner and with ST5
    do_cmd(9, 3'd0, 32'd0, 32'd0);
    do_cmd(9, 3'd5, 32'd0, 32'd0);
    // R7: rotations keep tags
    do_cmd(5, 3'd0, 32'd0, 32'd0);
    do_cmd(6, 3'd0, 32'd0, 32'd0);
    // R11: idle and undefined opcodes
    do_idle(1);
    do_cmd(0, 3'd0, 32'h5, 32'h6);
    do_cmd(13, 3'd1, 32'h5, 32'h6);
    // R10: init keeps data
    do_cmd(10, 3'd0, 32'd0, 32'd0);
    // R5: double pop with only ST0 full
    do_cmd(1, 3'd0, 32'h0000_0777, 32'd0);
    do_cmd(3, 3'd0, 32'd0, 32'd0);
    // R6: write then push from one entry
    do_cmd(4, 3'd0, 32'h0000_0AAA, 32'h0000_0BBB);
    do_cmd(3, 3'd0, 32'd0, 32'd0);
    // R8: free and free with pop
    do_cmd(1, 3'd0, 32'h10, 32'd0);
    do_cmd(1, 3'd0, 32'h20, 32'd0);
    do_cmd(7, 3'd1, 32'd0, 32'd0);
    do_cmd(8, 3'd3, 32'd0, 32'd0);

    // constrained random mix, pushes weighted up
    for (int n = 0; n < 1500; n++) begin
      int r, op;
      r = int'($urandom % 16);
      if (r < 4) op = 1;
      else if (r < 6) op = 2;
      else if (r == 15) op = int'($urandom % 16);
      else op = r - 3;
      if (op == 10 && ($urandom % 4) != 0) op = 4;
      if (($urandom % 10) == 0) do_idle(op);
      else do_cmd(op, 3'($urandom % 8), $urandom, $urandom);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule